// File: doc/BRIEF.md
# Tuner Control Register Slave on I2C

This block lets a host microcontroller program a radio tuner over a two-wire I2C bus. It answers at one fixed 7-bit device address and serves a bank of sixteen 8-bit registers. Their contents drive the tuner's analogue settings through a flat configuration output. The bus pins are first brought into the system clock domain. A small protocol engine then detects START, repeated START and STOP, shifts bytes in and out, and answers each byte on the data line through an open-drain pull-down.

A write transaction carries a register-address byte and then any number of data bytes. The register pointer steps forward after each data byte. A read first writes the register-address byte, then issues a repeated START with the direction bit set, and then clocks data out. During a read the pointer steps only when the master acknowledges a byte. Two read locations do not return stored data. One returns a live intermediate-frequency count and the other returns a live status word (AGC, soft-mute and signal strength). Both are supplied on input ports. The supported bus rate is fast mode, up to 400 kbit/s. The system clock must run at least about 16 times the SCL rate.

Top module: `i2c_tuner_regs`

## Requirements
- R1: The block responds only to device address 7'b1110010 followed by a direction bit (0 = write, 1 = read). It pulls SDA low in the ninth clock of a matching address byte. A byte with any other address gets no acknowledge, and the block ignores the bus until the next START.
- R2: Only bits [3:0] of the register-address byte select a register. Bits [7:4] have no effect.
- R3: Every byte travels MSB first. The block acknowledges the address byte, the register-address byte and every written data byte by driving SDA low during the ninth clock. It changes its SDA drive only after SCL has gone low.
- R4: In a write burst, data byte k lands in register (first + k) modulo 16, so the pointer wraps from 15 to 0.
- R5: After a register-address write, a repeated START and a read-direction address byte, the block returns the selected register's value, MSB first.
- R6: In a read burst the pointer advances by one only when the master answers a byte with ACK (SDA low). After a NACK the pointer stays, so a following read without a new register address returns that same register again.
- R7: A read at register 2 returns ifcnt_i and a read at register 15 returns stat_i. Values written to those addresses are still stored and appear on cfg_o.
- R8: A START or STOP that arrives before the eighth data bit of a byte aborts the transfer, and no register is written. A STOP releases SDA and returns the engine to idle.
- R9: A START always releases SDA and restarts address reception. The sequence START, nine clocks with SDA high, repeated START, STOP leaves the block idle with SDA released and ready for a normal transaction.
- R10: After reset SDA is released and all sixteen registers read as zero on cfg_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| ifcnt_i | input | 8 | Live IF count value, read at register 2 |
| stat_i | input | 8 | Live AGC / soft-mute / signal-strength status, read at register 15 |
| cfg_o | output | 128 | Register contents, register n at bits [8n+7:8n] |

## Verification
A bit counter that has slipped or a wrong protocol state shows up within one byte. It appears as a missing or misplaced acknowledge in the ninth clock, or as read data shifted by one bit position. A wrong register pointer stays hidden during writes until cfg_o is compared with the burst model. During reads it shows at the first byte returned after the error, which is why NACK-terminated bursts are followed by pointer-less reads. A state that fails to clear on START or STOP appears as SDA still held low, or as the next transaction going unacknowledged.

// File: rtl/i2c_tuner_pkg.sv
package i2c_tuner_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_ACK_A = 3'd2,
        ST_REG   = 3'd3,
        ST_ACK_W = 3'd4,
        ST_WDATA = 3'd5,
        ST_RDATA = 3'd6,
        ST_MACK  = 3'd7
    } i2c_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] scl;
        logic [DEPTH-1:0] sda;
    } sync_t;

    sync_t q, d;
    logic  scl_now, scl_prev, sda_prev;

    always_comb begin
        d     = q;
        d.scl = {q.scl[DEPTH-2:0], scl_i};
        d.sda = {q.sda[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_now   = q.scl[STAGES-1];
    assign scl_prev  = q.scl[STAGES];
    assign sda_s     = q.sda[STAGES-1];
    assign sda_prev  = q.sda[STAGES];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_evt = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_tuner_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1110010,
    parameter int         AW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST = BIT_CNT_W'(BYTE_W - 1);

    typedef struct packed {
        i2c_state_e           st;
        logic [BIT_CNT_W-1:0] cnt;
        logic [BYTE_W-1:0]    rx;
        logic [BYTE_W-1:0]    tx;
        logic [AW-1:0]        ptr;
        logic                 rw;
        logic                 mack;
        logic                 oe;
    } fsm_t;

    fsm_t          q, d;
    i2c_state_e    st_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_inc;

    assign st_q    = q.st;
    assign ptr_q   = q.ptr;
    assign ptr_inc = ptr_q + AW'(1);

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_addr = ptr_q;
        wr_data = q.rx;
        rd_addr = ptr_q;
        if (start_evt) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_evt) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (st_q)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && (q.cnt < FULL)) begin
                        d.rx  = {q.rx[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + BIT_CNT_W'(1);
                    end
                    if (scl_fall && (q.cnt == FULL)) begin
                        d.cnt = '0;
                        if (st_q == ST_ADDR) begin
                            if (q.rx[BYTE_W-1:1] == DEV_ADDR) begin
                                d.rw = q.rx[0];
                                d.oe = 1'b1;
                                d.st = ST_ACK_A;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (st_q == ST_REG) begin
                            d.ptr = q.rx[AW-1:0];
                            d.oe  = 1'b1;
                            d.st  = ST_ACK_W;
                        end else begin
                            wr_en = 1'b1;
                            d.ptr = ptr_inc;
                            d.oe  = 1'b1;
                            d.st  = ST_ACK_W;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.tx = rd_data;
                            d.oe = ~rd_data[BYTE_W-1];
                            d.st = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_REG;
                        end
                    end
                end
                ST_ACK_W: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        d.st  = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.cnt = '0;
                            d.oe  = 1'b0;
                            d.st  = ST_MACK;
                        end else begin
                            d.tx  = {q.tx[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.tx[BYTE_W-2];
                            d.cnt = q.cnt + BIT_CNT_W'(1);
                        end
                    end
                end
                ST_MACK: begin
                    rd_addr = ptr_inc;
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.ptr = ptr_inc;
                            d.tx  = rd_data;
                            d.oe  = ~rd_data[BYTE_W-1];
                            d.st  = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/i2c_tuner_regfile.sv
module i2c_tuner_regfile
    import i2c_tuner_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 4,
    parameter int IFCNT_ADDR = 2,
    parameter int STAT_ADDR  = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [AW-1:0]          rd_addr,
    input  logic [BYTE_W-1:0]      ifcnt_i,
    input  logic [BYTE_W-1:0]      stat_i,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [NREG*BYTE_W-1:0] cfg_o
);
    localparam int TOTAL_W = NREG * BYTE_W;

    logic [TOTAL_W-1:0] store_q, store_d;

    always_comb begin
        store_d = store_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (wr_addr == AW'(i))) begin
                store_d[i*BYTE_W +: BYTE_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    always_comb begin
        if (rd_addr == AW'(IFCNT_ADDR)) begin
            rd_data = ifcnt_i;
        end else if (rd_addr == AW'(STAT_ADDR)) begin
            rd_data = stat_i;
        end else begin
            rd_data = store_q[rd_addr*BYTE_W +: BYTE_W];
        end
    end

    assign cfg_o = store_q;

endmodule

// File: rtl/i2c_tuner_regs.sv
module i2c_tuner_regs
    import i2c_tuner_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1110010,
    parameter int         NREG        = 16,
    parameter int         IFCNT_ADDR  = 2,
    parameter int         STAT_ADDR   = 15,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [7:0]             ifcnt_i,
    input  logic [7:0]             stat_i,
    output logic [NREG*BYTE_W-1:0] cfg_o
);
    localparam int AW = $clog2(NREG);

    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    i2c_bus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_slave_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .AW       (AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    i2c_tuner_regfile #(
        .NREG       (NREG),
        .AW         (AW),
        .IFCNT_ADDR (IFCNT_ADDR),
        .STAT_ADDR  (STAT_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .ifcnt_i (ifcnt_i),
        .stat_i  (stat_i),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/i2c_slave_fsm_chk.sv
module i2c_slave_fsm_chk
    import i2c_tuner_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_fall,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          wr_en,
    input i2c_state_e    st_q,
    input logic [AW-1:0] ptr_q
);
    // R1: no drive while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_oe);

    // R3: drive only begins right after a synchronised SCL fall
    p_drive_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R4: pointer moves by exactly one, except when loaded from the register byte
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr_q) && ($past(st_q) != ST_REG)) |-> (ptr_q == AW'($past(ptr_q) + AW'(1))));

    // R8: STOP releases the line and idles the engine
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> ((st_q == ST_IDLE) && !sda_oe));

    // R8: a register write is a single-cycle strobe
    p_write_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R9: START releases the line and restarts address reception
    p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> ((st_q == ST_ADDR) && !sda_oe));

endmodule

bind i2c_slave_fsm i2c_slave_fsm_chk #(
    .AW (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .wr_en     (wr_en),
    .st_q      (st_q),
    .ptr_q     (ptr_q)
);

// File: tb/sim_i2c_tuner_regs.sv
module sim_i2c_tuner_regs;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int NREG       = 16;
    localparam logic [7:0] AW_BYTE = 8'hE4;  // 1110010 + write
    localparam logic [7:0] AR_BYTE = 8'hE5;  // 1110010 + read

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] ifcnt = 8'h00;
    logic [7:0] stat = 8'h00;
    logic [NREG*8-1:0] cfg;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl [NREG];
    logic [7:0] wbuf [8];
    logic [3:0] bptr = 4'd0;

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tuner_regs u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .ifcnt_i (ifcnt),
        .stat_i  (stat),
        .cfg_o   (cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        if (a == 4'd2) return ifcnt;
        if (a == 4'd15) return stat;
        return mdl[a];
    endfunction

    task automatic wq;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b0; wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wq;
        scl_m = 1'b1; wq;
        sda_m = 1'b1; wq;
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq;
        scl_m = 1'b1; wq;
        wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq;
        scl_m = 1'b1; wq;
        ack = ~sda_line;
        wq;
        scl_m = 1'b0; wq;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq;
            scl_m = 1'b1; wq;
            b[i] = sda_line;
            wq;
            scl_m = 1'b0; wq;
        end
        put_bit(~mack);
    endtask

    task automatic do_write(input logic [7:0] regbyte, input int n);
        logic ack;
        i2c_start;
        wr_byte(AW_BYTE, ack);
        chk("R1 address ack (write)", ack, 1);
        wr_byte(regbyte, ack);
        chk("R3 register byte ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], ack);
            chk("R3 data byte ack", ack, 1);
            mdl[4'(regbyte[3:0] + k)] = wbuf[k];
        end
        bptr = 4'(regbyte[3:0] + n);
        i2c_stop;
    endtask

    task automatic check_cfg(input string tag);
        for (int a = 0; a < NREG; a++) chk(tag, cfg[a*8 +: 8], mdl[a]);
    endtask

    task automatic do_read(input logic [7:0] regbyte, input logic set_addr, input int n, input string tag);
        logic ack;
        logic [7:0] got;
        i2c_start;
        if (set_addr) begin
            wr_byte(AW_BYTE, ack);
            chk("R1 address ack (write)", ack, 1);
            wr_byte(regbyte, ack);
            chk("R2 register byte ack", ack, 1);
            bptr = regbyte[3:0];
            i2c_start;
        end
        wr_byte(AR_BYTE, ack);
        chk("R1 address ack (read)", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, got);
            chk(tag, got, exp_rd(bptr));
            if (k != n - 1) bptr = bptr + 4'd1;
        end
        i2c_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] got;
        void'($urandom(32'd20240611));
        for (int a = 0; a < NREG; a++) mdl[a] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wq;

        // R10: reset state
        chk("R10 sda released after reset", sda_oe, 0);
        check_cfg("R10 registers zero after reset");

        // R3/R2: single write, upper nibble of register byte set
        wbuf[0] = 8'hA5;
        do_write(8'hF3, 1);
        chk("R2 upper nibble ignored, reg 3", cfg[3*8 +: 8], 8'hA5);
        check_cfg("R3 MSB-first single write");

        // R1: wrong device address is not acknowledged and ignored
        i2c_start;
        wr_byte(8'hE6, ack);
        chk("R1 wrong address not acked", ack, 0);
        wr_byte(8'h03, ack);
        chk("R1 ignored after mismatch", ack, 0);
        wr_byte(8'h11, ack);
        chk("R1 ignored data after mismatch", ack, 0);
        i2c_stop;
        chk("R1 reg 3 untouched", cfg[3*8 +: 8], 8'hA5);
        i2c_start;
        wr_byte(8'hA5, ack);
        chk("R1 wrong read address not acked", ack, 0);
        i2c_stop;

        // R4: burst write wrapping 15 -> 0
        wbuf[0] = 8'h81; wbuf[1] = 8'h42; wbuf[2] = 8'h1C;
        do_write(8'h0E, 3);
        chk("R4 wrap lands in reg 0", cfg[0 +: 8], 8'h1C);
        check_cfg("R4 burst write wrap");

        // R5: read via repeated start
        do_read(8'h03, 1'b1, 1, "R5 read reg 3");

        // R7: status locations
        ifcnt = 8'h9B; stat = 8'h4E;
        wbuf[0] = 8'h3C;
        do_write(8'h02, 1);
        wbuf[0] = 8'hC3;
        do_write(8'h0F, 1);
        chk("R7 reg 2 stored on cfg", cfg[2*8 +: 8], 8'h3C);
        chk("R7 reg 15 stored on cfg", cfg[15*8 +: 8], 8'hC3);
        do_read(8'h02, 1'b1, 1, "R7 read 2 gives ifcnt");
        do_read(8'h0F, 1'b1, 1, "R7 read 15 gives stat");

        // R6: burst read with ACK advance, NACK hold
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(8'h04, 3);
        do_read(8'h04, 1'b1, 3, "R6 burst read ack advance");
        do_read(8'h00, 1'b0, 1, "R6 NACK holds pointer");
        chk("R6 pointer held at reg 6", bptr, 4'd6);

        // R8: STOP in the middle of a data byte
        wbuf[0] = 8'h77;
        do_write(8'h07, 1);
        i2c_start;
        wr_byte(AW_BYTE, ack);
        wr_byte(8'h07, ack);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        i2c_stop;
        chk("R8 STOP mid-byte, no write", cfg[7*8 +: 8], 8'h77);
        chk("R8 sda released after STOP", sda_oe, 0);

        // R8: START in the middle of a data byte
        i2c_start;
        wr_byte(AW_BYTE, ack);
        wr_byte(8'h08, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        i2c_start;
        wr_byte(AW_BYTE, ack);
        chk("R9 address acked after restart", ack, 1);
        wr_byte(8'h09, ack);
        wr_byte(8'h5A, ack);
        i2c_stop;
        mdl[9] = 8'h5A;
        chk("R8 START mid-byte, reg 8 kept", cfg[8*8 +: 8], mdl[8]);
        chk("R8 restart write lands", cfg[9*8 +: 8], 8'h5A);

        // R9: software reset while a read is under way
        wbuf[0] = 8'h00;
        do_write(8'h0A, 1);
        i2c_start;
        wr_byte(AW_BYTE, ack);
        wr_byte(8'h0A, ack);
        i2c_start;
        wr_byte(AR_BYTE, ack);
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b1; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
        end
        i2c_start;
        for (int i = 0; i < 9; i++) put_bit(1'b1);
        i2c_start;
        i2c_stop;
        chk("R9 sda released after software reset", sda_oe, 0);
        do_read(8'h03, 1'b1, 1, "R9 normal read after software reset");

        // Random mix: bursts of writes and reads against the model
        for (int t = 0; t < 20; t++) begin
            int n;
            logic [7:0] rb;
            ifcnt = 8'($urandom);
            stat  = 8'($urandom);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            rb = 8'($urandom);
            do_write(rb, n);
            check_cfg("R4 random burst write");
            rb = 8'($urandom);
            do_read(rb, 1'b1, 1 + int'($urandom % 4), "R6 random burst read");
        end

        // R6: final pointer-less read
        do_read(8'h00, 1'b0, 1, "R6 pointer-less read after random mix");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule